// File: doc/BRIEF.md
# Packet-Aware DMA Transmit Channel

This block is one DMA channel that feeds a frame-oriented serial transmitter from memory. Software builds a chain of buffer descriptors in memory and pulses `start` with the address of the first one. The channel then reads the descriptors and copies each buffer's bytes into the transmitter's data register. It sends a byte only while the transmitter reports room for one. When a buffer is not the final one, the channel follows its next pointer and the packet carries on across the buffer boundary.

The channel can mark the closing byte of a frame. For that byte it raises `per_last`, which steers the write to the transmitter's end-of-frame register; the transmitter then closes the frame and appends its check sequence. When the chain is finished, the channel writes the transmitter's status byte into the head descriptor of the chain, even if a later descriptor was in use at the time. It then pulses `done` and reports any error bits in `err`. Between any two memory or register accesses the channel may lose the shared bus. When the bus comes back, it carries on from the byte it had not yet delivered.

Top module: `pkt_dma_tx`

## Requirements
- R1: A `start` pulse while `busy` is low latches `head_addr` as the chain head and raises `busy`. A `start` pulse while `busy` is high has no effect on the transfer.
- R2: A descriptor is 8 bytes at consecutive addresses. Bytes 0-1 hold the source address, bytes 2-3 the byte count and bytes 4-5 the next-descriptor pointer, all low byte first. Byte 6 holds the flags: bit0 asks for end-of-frame marking, bit1 marks the final buffer. Byte 7 receives the status.
- R3: A byte is fetched only after `per_req` has been seen high since the previous peripheral write. Each byte produces exactly one `per_wr`, carrying the memory bytes in address order.
- R4: `per_last` is 1 only on the write of the final byte of a buffer whose flags have both bit0 and bit1 set. It is 0 on every other write.
- R5: A buffer without bit1 set is followed by the descriptor at its next pointer, and the packet continues. All of its bytes go out with `per_last` at 0, even when its bit0 is set.
- R6: At the end of the chain, the channel writes the value on `per_status` to address head+7. No other descriptor's status byte is written.
- R7: A descriptor with a byte count of zero produces no peripheral write. The chain then proceeds as for an emptied buffer.
- R8: No memory access and no peripheral write is issued in a cycle with `bus_gnt` low. After a stall the transfer resumes with the byte not yet written.
- R9: `done` is high for exactly one cycle, the cycle after the status write. In that cycle `err` equals the OR of the written status ANDed with ERR_MASK (default 8'h0F). `err` then holds until the next accepted start.
- R10: After reset, `busy`, `done`, `err`, `mem_req` and `per_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a chain at `head_addr` |
| head_addr | input | 16 | Address of the first descriptor |
| bus_gnt | input | 1 | Shared bus available this cycle |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read strobe |
| per_req | input | 1 | Transmitter has room for a byte |
| per_wr | output | 1 | Peripheral register write strobe |
| per_last | output | 1 | Write targets the end-of-frame register |
| per_wdata | output | 8 | Peripheral write data |
| per_status | input | 8 | Transmitter status byte |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error bits were present in the written status |

## Verification
The assertions rely on three properties of the surroundings. Memory returns read data exactly one cycle after a read strobe. `per_req` falls no later than the cycle after a peripheral write and stays low until the transmitter has drained. `per_status` is steady while the status write is taking place. The bench models the memory with a one-cycle read register and the transmitter with a one-entry buffer that drains after a fixed delay. It changes `per_status` only between chains. `bus_gnt` is driven either constantly high or from a pseudo-random sequence, so that stalls fall on every kind of access.

// File: rtl/pkt_dma_pkg.sv
package pkt_dma_pkg;
    localparam int ADDR_W      = 16;
    localparam int PTR_BYTES   = ADDR_W / 8;
    localparam int FLAG_W      = 2;
    localparam int FLAG_LAST   = 0;
    localparam int FLAG_FINAL  = 1;
    localparam int OFF_SRC     = 0;
    localparam int OFF_CNT     = PTR_BYTES;
    localparam int OFF_NXT     = 2 * PTR_BYTES;
    localparam int OFF_FLAGS   = 3 * PTR_BYTES;
    localparam int OFF_STAT    = OFF_FLAGS + 1;
    localparam int FETCH_BYTES = OFF_FLAGS + 1;
    localparam int DESC_BITS   = 3 * ADDR_W + FLAG_W;
    localparam int IDX_W       = $clog2(FETCH_BYTES);

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_DESC,
        S_WAIT_REQ,
        S_READ_BYTE,
        S_WRITE_REG,
        S_NEXT_DESC,
        S_WRITE_STATUS,
        S_DONE
    } dma_state_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] cnt;
        logic [ADDR_W-1:0] src;
    } desc_t;
endpackage

// File: rtl/pkt_dma_desc_regs.sv
module pkt_dma_desc_regs
    import pkt_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [7:0]       cap_data,
    output desc_t            desc
);
    logic [DESC_BITS-1:0] flat;

    for (genvar i = 0; i < FETCH_BYTES; i++) begin : g_byte
        if (i == OFF_FLAGS) begin : g_flag
            logic [FLAG_W-1:0] byte_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    byte_q <= '0;
                else if (cap_en && cap_idx == IDX_W'(i))
                    byte_q <= cap_data[FLAG_W-1:0];
            end
            assign flat[i*8 +: FLAG_W] = byte_q;
        end else begin : g_full
            logic [7:0] byte_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    byte_q <= '0;
                else if (cap_en && cap_idx == IDX_W'(i))
                    byte_q <= cap_data;
            end
            assign flat[i*8 +: 8] = byte_q;
        end
    end

    assign desc = desc_t'(flat);
endmodule

// File: rtl/pkt_dma_seq.sv
module pkt_dma_seq
    import pkt_dma_pkg::*;
#(
    parameter logic [7:0] ERR_MASK = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic              bus_gnt,
    input  desc_t             desc,
    output logic              cap_en,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              per_req,
    output logic              per_wr,
    output logic              per_last,
    output logic [7:0]        per_wdata,
    input  logic [7:0]        per_status,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(FETCH_BYTES - 1);
    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);

    typedef struct packed {
        dma_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic              pend;
        logic [ADDR_W-1:0] desc_a;
        logic [ADDR_W-1:0] head;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] cnt;
        logic [7:0]        data;
        logic              err;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic frame_end;
    assign frame_end = desc.flags[FLAG_LAST] && desc.flags[FLAG_FINAL];

    always_comb begin
        r_d       = r_q;
        cap_en    = 1'b0;
        cap_idx   = r_q.idx;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        per_wr    = 1'b0;
        per_last  = 1'b0;
        per_wdata = r_q.data;
        done      = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.head   = head_addr;
                    r_d.desc_a = head_addr;
                    r_d.idx    = '0;
                    r_d.pend   = 1'b0;
                    r_d.err    = 1'b0;
                    r_d.st     = S_FETCH_DESC;
                end
            end
            S_FETCH_DESC: begin
                if (r_q.pend) begin
                    cap_en   = 1'b1;
                    r_d.pend = 1'b0;
                    if (r_q.idx == LAST_IDX) begin
                        r_d.src = desc.src;
                        r_d.cnt = desc.cnt;
                        r_d.st  = (desc.cnt == '0) ? S_NEXT_DESC : S_WAIT_REQ;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end else if (bus_gnt) begin
                    mem_req  = 1'b1;
                    mem_addr = r_q.desc_a + ADDR_W'(r_q.idx);
                    r_d.pend = 1'b1;
                end
            end
            S_WAIT_REQ: begin
                if (per_req && bus_gnt) begin
                    mem_req  = 1'b1;
                    mem_addr = r_q.src;
                    r_d.st   = S_READ_BYTE;
                end
            end
            S_READ_BYTE: begin
                r_d.data = mem_rdata;
                r_d.st   = S_WRITE_REG;
            end
            S_WRITE_REG: begin
                if (bus_gnt) begin
                    per_wr   = 1'b1;
                    per_last = frame_end && (r_q.cnt == ONE);
                    r_d.src  = r_q.src + ONE;
                    r_d.cnt  = r_q.cnt - ONE;
                    r_d.st   = (r_q.cnt == ONE) ? S_NEXT_DESC : S_WAIT_REQ;
                end
            end
            S_NEXT_DESC: begin
                if (desc.flags[FLAG_FINAL]) begin
                    r_d.st = S_WRITE_STATUS;
                end else begin
                    r_d.desc_a = desc.nxt;
                    r_d.idx    = '0;
                    r_d.st     = S_FETCH_DESC;
                end
            end
            S_WRITE_STATUS: begin
                if (bus_gnt) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = r_q.head + ADDR_W'(OFF_STAT);
                    mem_wdata = per_status;
                    r_d.err   = |(per_status & ERR_MASK);
                    r_d.st    = S_DONE;
                end
            end
            S_DONE: begin
                done   = 1'b1;
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st != S_IDLE);
    assign err  = r_q.err;
endmodule

// File: rtl/pkt_dma_tx.sv
module pkt_dma_tx
    import pkt_dma_pkg::*;
#(
    parameter logic [7:0] ERR_MASK = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic              bus_gnt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              per_req,
    output logic              per_wr,
    output logic              per_last,
    output logic [7:0]        per_wdata,
    input  logic [7:0]        per_status,
    output logic              busy,
    output logic              done,
    output logic              err
);
    desc_t            desc;
    logic             cap_en;
    logic [IDX_W-1:0] cap_idx;

    pkt_dma_desc_regs u_desc (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .cap_data (mem_rdata),
        .desc     (desc)
    );

    pkt_dma_seq #(.ERR_MASK(ERR_MASK)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .head_addr  (head_addr),
        .bus_gnt    (bus_gnt),
        .desc       (desc),
        .cap_en     (cap_en),
        .cap_idx    (cap_idx),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .per_req    (per_req),
        .per_wr     (per_wr),
        .per_last   (per_last),
        .per_wdata  (per_wdata),
        .per_status (per_status),
        .busy       (busy),
        .done       (done),
        .err        (err)
    );
endmodule

// File: rtl/pkt_dma_tx_chk.sv
module pkt_dma_tx_chk
    import pkt_dma_pkg::*;
#(
    parameter logic [7:0] ERR_MASK = 8'h0F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] head_addr,
    input logic              busy,
    input logic              bus_gnt,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              per_req,
    input logic              per_wr,
    input logic              per_last,
    input logic              done,
    input logic              err
);
    logic [ADDR_W-1:0] head_lat_q;
    logic              seen_req_q;
    logic [7:0]        stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_lat_q <= '0;
            seen_req_q <= 1'b0;
            stat_q     <= '0;
        end else begin
            if (start && !busy)
                head_lat_q <= head_addr;
            if (per_wr)
                seen_req_q <= 1'b0;
            else if (per_req)
                seen_req_q <= 1'b1;
            if (mem_req && mem_we)
                stat_q <= mem_wdata;
        end
    end

    a_r8_mem_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> bus_gnt);
    a_r8_per_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |-> bus_gnt);
    a_r3_write_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |-> seen_req_q);
    a_r4_last_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        per_last |-> per_wr);
    a_r6_status_to_head: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == head_lat_q + ADDR_W'(OFF_STAT)));
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_after_status: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> done);
    a_r9_err_value: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err == |(stat_q & ERR_MASK)));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !per_wr && !done));
endmodule

bind pkt_dma_tx pkt_dma_tx_chk #(.ERR_MASK(ERR_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .head_addr (head_addr),
    .busy      (busy),
    .bus_gnt   (bus_gnt),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .per_req   (per_req),
    .per_wr    (per_wr),
    .per_last  (per_last),
    .done      (done),
    .err       (err)
);

// File: tb/pkt_dma_tx_bench.sv
module pkt_dma_tx_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] head_addr = '0;
    logic        bus_gnt = 1'b1;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        per_req;
    logic        per_wr, per_last;
    logic [7:0]  per_wdata;
    logic [7:0]  per_status = '0;
    logic        busy, done, err;

    int checks = 0;
    int fails  = 0;
    logic [8:0]  exp_q[$];
    logic [15:0] exp_stat_addr = '0;
    bit          stall_mode = 1'b0;
    bit          finished = 1'b0;

    logic [7:0]  mem [0:4095];
    logic        full = 1'b0;
    int          drain = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_dma_tx u_pkt_dma_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .head_addr(head_addr),
        .bus_gnt(bus_gnt), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .per_req(per_req), .per_wr(per_wr), .per_last(per_last),
        .per_wdata(per_wdata), .per_status(per_status), .busy(busy),
        .done(done), .err(err)
    );

    // memory model: read data one cycle after the strobe
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:0]];
        if (mem_req && mem_we)  mem[mem_addr[11:0]] <= mem_wdata;
    end

    // transmitter model: one-entry buffer that drains after a few cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0; drain <= 0;
        end else if (per_wr) begin
            full <= 1'b1; drain <= 3;
        end else if (full) begin
            if (drain == 0) full <= 1'b0;
            else drain <= drain - 1;
        end
    end
    assign per_req = !full;

    // bus grant source
    initial begin
        logic [7:0] lfsr = 8'hA5;
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            bus_gnt = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every peripheral write
    always @(negedge clk) begin
        if (rst_n && per_wr) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected peripheral write", {23'd0, per_last, per_wdata}, 32'd0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({per_last, per_wdata} == e, "R3 R4 byte and last marker",
                    {23'd0, per_last, per_wdata}, {23'd0, e});
            end
        end
        if (rst_n && mem_req && mem_we) begin
            chk(mem_addr == exp_stat_addr, "R6 status address", {16'd0, mem_addr}, {16'd0, exp_stat_addr});
            chk(mem_wdata == per_status, "R6 status value", {24'd0, mem_wdata}, {24'd0, per_status});
        end
    end

    // driver: lay out one descriptor with its data and push the expected bytes
    task automatic add_buf(input logic [15:0] da, input logic [15:0] src, input int n,
                           input logic [15:0] nxt, input logic [7:0] flags, input logic [7:0] seed);
        mem[da[11:0]]       = src[7:0];
        mem[da[11:0] + 1]   = src[15:8];
        mem[da[11:0] + 2]   = n[7:0];
        mem[da[11:0] + 3]   = n[15:8];
        mem[da[11:0] + 4]   = nxt[7:0];
        mem[da[11:0] + 5]   = nxt[15:8];
        mem[da[11:0] + 6]   = flags;
        mem[da[11:0] + 7]   = 8'hEE;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = seed + 8'(i * 37);
            mem[src[11:0] + 12'(i)] = b;
            exp_q.push_back({(i == n - 1) && (flags[1:0] == 2'b11), b});
        end
    endtask

    task automatic run_job(input logic [15:0] head, input logic [7:0] stat,
                           input bit stall, input bit poke, input string tag);
        bit seen = 1'b0;
        exp_stat_addr = head + 16'd7;
        per_status    = stat;
        stall_mode    = stall;
        @(posedge clk); #1;
        head_addr = head; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke) begin
            repeat (4) @(posedge clk);
            #1;
            chk(busy, "R1 busy while running", {31'd0, busy}, 32'd1);
            head_addr = 16'h0800; start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0; head_addr = head;
        end
        for (int k = 0; k < 20000 && !seen; k++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk(seen, {tag, " R9 done seen"}, {31'd0, seen}, 32'd1);
        chk(exp_q.size() == 0, {tag, " R3 all bytes sent"}, exp_q.size(), 32'd0);
        chk(err == |(stat & 8'h0F), {tag, " R9 err flag"}, {31'd0, err}, {31'd0, |(stat & 8'h0F)});
        @(negedge clk);
        chk(!done, {tag, " R9 done one cycle"}, {31'd0, done}, 32'd0);
        chk(err == |(stat & 8'h0F), {tag, " R9 err holds"}, {31'd0, err}, {31'd0, |(stat & 8'h0F)});
        chk(mem[head[11:0] + 7] == stat, {tag, " R6 head status byte"}, {24'd0, mem[head[11:0] + 7]}, {24'd0, stat});
        stall_mode = 1'b0;
        exp_q.delete();
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && !err && !mem_req && !per_wr, "R10 idle while in reset",
            {27'd0, busy, done, err, mem_req, per_wr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && !mem_req && !per_wr, "R10 idle after reset",
            {27'd0, busy, done, err, mem_req, per_wr}, 32'd0);

        // R2 R4: single buffer with both flags
        add_buf(16'h0100, 16'h0400, 4, 16'h0000, 8'h03, 8'h11);
        run_job(16'h0100, 8'h00, 1'b0, 1'b0, "single");

        // R5 R6: two-buffer chain, first has only the end-marking flag
        add_buf(16'h0110, 16'h0420, 3, 16'h0120, 8'h01, 8'h22);
        add_buf(16'h0120, 16'h0440, 2, 16'h0000, 8'h03, 8'h33);
        run_job(16'h0110, 8'h05, 1'b0, 1'b0, "chain");
        chk(mem[12'h127] == 8'hEE, "R6 second status untouched", {24'd0, mem[12'h127]}, 32'hEE);

        // R4: final buffer without end-marking flag, no last marker
        add_buf(16'h0130, 16'h0460, 3, 16'h0000, 8'h02, 8'h44);
        run_job(16'h0130, 8'hF0, 1'b0, 1'b0, "nomark");

        // R7: zero-count buffer in the middle of a chain
        add_buf(16'h0140, 16'h0480, 2, 16'h0150, 8'h00, 8'h55);
        add_buf(16'h0150, 16'h04A0, 0, 16'h0160, 8'h01, 8'h00);
        add_buf(16'h0160, 16'h04C0, 3, 16'h0000, 8'h03, 8'h66);
        run_job(16'h0140, 8'h01, 1'b0, 1'b0, "zero");
        chk(mem[12'h157] == 8'hEE, "R7 empty descriptor status untouched", {24'd0, mem[12'h157]}, 32'hEE);

        // R8: bus stalls across a chain
        add_buf(16'h0170, 16'h0500, 5, 16'h0180, 8'h01, 8'h77);
        add_buf(16'h0180, 16'h0520, 4, 16'h0000, 8'h03, 8'h88);
        run_job(16'h0170, 8'h08, 1'b1, 1'b0, "stall");

        // R1: start while busy is ignored
        mem[12'h807] = 8'hEE;
        add_buf(16'h0190, 16'h0540, 4, 16'h0000, 8'h03, 8'h99);
        run_job(16'h0190, 8'h00, 1'b0, 1'b1, "poke");
        chk(mem[12'h807] == 8'hEE, "R1 second start left no status", {24'd0, mem[12'h807]}, 32'hEE);
        @(negedge clk);
        chk(!busy, "R1 idle after single run", {31'd0, busy}, 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule